// File: doc/BRIEF.md
# Deferred Register Write-Back Log

This block sits beside a register file and collects the register writes of an extension operation that runs in parallel with a main operation. Both operations read the register state as it was before the instruction. The extension writes are parked in a small log of up to four (register index, value) slots. After the main operation has written its results, an apply walk commits the parked writes to the register file and leaves the log empty.

A static configuration input selects precise mode. In precise mode each committed value is the parked value ORed with the current register contents. A separate zero walk, issued after the main operation has sampled its inputs, writes zero to every register named in the log. Main and extension results that target the same register therefore end up merged by OR. The zero walk can be told to spare the three words of one accumulator.

The controller is a three-state machine. ST_IDLE accepts pushes and requests. In ST_IDLE an apply request moves to ST_APPLY; otherwise a zero request in precise mode moves to ST_ZERO. In ST_APPLY and ST_ZERO one slot is handled per cycle. Both return to ST_IDLE on the first empty slot or after the last slot; the return from ST_APPLY also empties the log.

Top module: `dwb_log`

## Requirements
- R1: After reset `busy` and `rf_we` are low and the log is empty, so an apply walk writes nothing.
- R2: A push while idle stores `log_idx`/`log_val` in the slot named by the 2-bit `log_slot`; a later push to the same slot replaces it.
- R3: An apply request while idle writes the filled slots in slot order 0,1,2,3, one per cycle, starting in the cycle after the request. The walk stops at the first empty slot. `busy` is high for n+1 cycles for n<4 filled slots, and for 4 cycles when all four are filled.
- R4: When an apply walk ends, every slot is empty, so an immediate second apply writes nothing.
- R5: With `precise_en` low, an applied write carries exactly the parked value.
- R6: With `precise_en` high, an applied write carries the parked value ORed with `rf_rdata`, where `rf_ridx` names the register being written. A repeated index sees the earlier write.
- R7: With `precise_en` high, a zero request while idle writes zero to each logged register in slot order with the same timing as R3, and leaves the log intact for the later apply.
- R8: A zero walk with `zero_keep_en` set skips indices 16+a, 18+a and 20+a, where a is `zero_keep_acc` (the low, middle and high words of accumulator a). The keep inputs are sampled with the request.
- R9: With `precise_en` low, a zero request has no effect: `busy` stays low, nothing is written and the log is kept.
- R10: While `busy` is high, pushes, apply requests and zero requests are ignored, and `rf_we` is never high while `busy` is low.
- R11: A push in the same idle cycle as an apply request is stored and included in that apply walk.
- R12: An apply request and a zero request in the same idle cycle start an apply walk; the zero request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| precise_en | input | 1 | Static mode select: 1 = OR merge and zero walk enabled |
| log_push | input | 1 | Park one extension write |
| log_slot | input | 2 | Slot that receives the pushed write |
| log_idx | input | 5 | Register index of the pushed write |
| log_val | input | 16 | Value of the pushed write |
| apply_req | input | 1 | Start the apply walk |
| zero_req | input | 1 | Start the zero walk (precise mode only) |
| zero_keep_en | input | 1 | Spare one accumulator during the zero walk |
| zero_keep_acc | input | 1 | Accumulator spared by the zero walk |
| busy | output | 1 | A walk is in progress |
| rf_ridx | output | 5 | Register read index for the OR merge |
| rf_rdata | input | 16 | Register contents at `rf_ridx` |
| rf_we | output | 1 | Register file write enable |
| rf_widx | output | 5 | Register file write index |
| rf_wdata | output | 16 | Register file write data |

## Verification
Two pairs of functions can fall in the same cycle. The first is a push and the start of an apply walk. It is provoked by raising `log_push` and `apply_req` together on an empty log, and it is judged by the apply writing exactly the pushed entry. The second is an apply request and a zero request in one idle cycle. It is judged by the written value: the apply must carry the parked value (ORed in precise mode), and no zero write may appear. Requests and pushes raised in the middle of a walk are also checked; they must leave no trace in the written sequence or in the log.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_APPLY = 2'd1,
        ST_ZERO  = 2'd2
    } dwb_state_e;

endpackage

// File: rtl/dwb_slots.sv
module dwb_slots #(
    parameter int NSLOT  = 4,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_slot,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              clr_all,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_val,
    output logic [NSLOT-1:0]  valid_vec
);

    logic [IDX_W-1:0]  idx_q [NSLOT];
    logic [DATA_W-1:0] val_q [NSLOT];
    logic [NSLOT-1:0]  valid_q;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_slot == PTR_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[s] <= 1'b0;
                idx_q[s]   <= '0;
                val_q[s]   <= '0;
            end else if (clr_all) begin
                valid_q[s] <= 1'b0;
            end else if (hit) begin
                valid_q[s] <= 1'b1;
                idx_q[s]   <= wr_idx;
                val_q[s]   <= wr_val;
            end
        end
    end

    always_comb begin
        rd_valid  = valid_q[rd_ptr];
        rd_idx    = idx_q[rd_ptr];
        rd_val    = val_q[rd_ptr];
        valid_vec = valid_q;
    end

endmodule

// File: rtl/dwb_seq.sv
module dwb_seq
    import dwb_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int PTR_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             precise_en,
    input  logic             apply_req,
    input  logic             zero_req,
    input  logic             keep_en_in,
    input  logic             keep_acc_in,
    input  logic             cur_valid,
    output logic [PTR_W-1:0] ptr,
    output logic             apply_phase,
    output logic             zero_phase,
    output logic             clr_all,
    output logic             busy,
    output logic             keep_en,
    output logic             keep_acc
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NSLOT - 1);

    dwb_state_e state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic keep_en_q, keep_acc_q;
    logic walk_end;

    assign walk_end = !cur_valid || (ptr_q == LAST);

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                ptr_d = '0;
                if (apply_req)
                    state_d = ST_APPLY;
                else if (zero_req && precise_en)
                    state_d = ST_ZERO;
            end
            ST_APPLY, ST_ZERO: begin
                if (walk_end) begin
                    state_d = ST_IDLE;
                    ptr_d   = '0;
                end else begin
                    ptr_d = ptr_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ptr_q      <= '0;
            keep_en_q  <= 1'b0;
            keep_acc_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            if (state_q == ST_IDLE && zero_req && !apply_req) begin
                keep_en_q  <= keep_en_in;
                keep_acc_q <= keep_acc_in;
            end
        end
    end

    always_comb begin
        apply_phase = 1'b0;
        zero_phase  = 1'b0;
        clr_all     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_APPLY: begin
                apply_phase = 1'b1;
                clr_all     = walk_end;
            end
            ST_ZERO:  zero_phase = 1'b1;
            default:  ;
        endcase
        busy     = apply_phase || zero_phase;
        ptr      = ptr_q;
        keep_en  = keep_en_q;
        keep_acc = keep_acc_q;
    end

    AST_ZERO_NEEDS_PRECISE: assert property (@(posedge clk) disable iff (!rst_n)
        !precise_en |-> state_q != ST_ZERO); // R9

    AST_WALK_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) && (ptr_q == LAST) |=> state_q == ST_IDLE); // R3

endmodule

// File: rtl/dwb_wdata.sv
module dwb_wdata #(
    parameter int IDX_W        = 5,
    parameter int DATA_W       = 16,
    parameter int ACC_LO_BASE  = 16,
    parameter int ACC_MID_BASE = 18,
    parameter int ACC_HI_BASE  = 20
) (
    input  logic              apply_phase,
    input  logic              zero_phase,
    input  logic              precise_en,
    input  logic              cur_valid,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [DATA_W-1:0] cur_val,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic              keep_en,
    input  logic              keep_acc,
    output logic              we,
    output logic [IDX_W-1:0]  widx,
    output logic [DATA_W-1:0] wdata
);

    logic [IDX_W-1:0] acc_off;
    logic             spared;

    assign acc_off = IDX_W'(keep_acc);

    always_comb begin
        spared = keep_en &&
                 ((cur_idx == IDX_W'(ACC_LO_BASE)  + acc_off) ||
                  (cur_idx == IDX_W'(ACC_MID_BASE) + acc_off) ||
                  (cur_idx == IDX_W'(ACC_HI_BASE)  + acc_off));
        widx  = cur_idx;
        we    = 1'b0;
        wdata = '0;
        if (apply_phase && cur_valid) begin
            we    = 1'b1;
            wdata = precise_en ? (cur_val | rf_rdata) : cur_val;
        end else if (zero_phase && cur_valid && !spared) begin
            we    = 1'b1;
            wdata = '0;
        end
    end

endmodule

// File: rtl/dwb_log.sv
module dwb_log #(
    parameter int NSLOT        = 4,
    parameter int IDX_W        = 5,
    parameter int DATA_W       = 16,
    parameter int ACC_LO_BASE  = 16,
    parameter int ACC_MID_BASE = 18,
    parameter int ACC_HI_BASE  = 20,
    localparam int PTR_W       = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              precise_en,
    input  logic              log_push,
    input  logic [PTR_W-1:0]  log_slot,
    input  logic [IDX_W-1:0]  log_idx,
    input  logic [DATA_W-1:0] log_val,
    input  logic              apply_req,
    input  logic              zero_req,
    input  logic              zero_keep_en,
    input  logic              zero_keep_acc,
    output logic              busy,
    output logic [IDX_W-1:0]  rf_ridx,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_widx,
    output logic [DATA_W-1:0] rf_wdata
);

    logic [PTR_W-1:0]  ptr;
    logic              apply_phase, zero_phase, clr_all;
    logic              keep_en, keep_acc;
    logic              cur_valid;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] cur_val;
    logic [NSLOT-1:0]  slot_valid;
    logic              push_ok;

    assign push_ok = log_push && !busy;

    dwb_slots #(.NSLOT(NSLOT), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push_ok), .wr_slot(log_slot), .wr_idx(log_idx), .wr_val(log_val),
        .clr_all(clr_all), .rd_ptr(ptr),
        .rd_valid(cur_valid), .rd_idx(cur_idx), .rd_val(cur_val),
        .valid_vec(slot_valid)
    );

    dwb_seq #(.NSLOT(NSLOT)) u_seq (
        .clk(clk), .rst_n(rst_n), .precise_en(precise_en),
        .apply_req(apply_req), .zero_req(zero_req),
        .keep_en_in(zero_keep_en), .keep_acc_in(zero_keep_acc),
        .cur_valid(cur_valid), .ptr(ptr),
        .apply_phase(apply_phase), .zero_phase(zero_phase),
        .clr_all(clr_all), .busy(busy),
        .keep_en(keep_en), .keep_acc(keep_acc)
    );

    dwb_wdata #(
        .IDX_W(IDX_W), .DATA_W(DATA_W),
        .ACC_LO_BASE(ACC_LO_BASE), .ACC_MID_BASE(ACC_MID_BASE), .ACC_HI_BASE(ACC_HI_BASE)
    ) u_wdata (
        .apply_phase(apply_phase), .zero_phase(zero_phase), .precise_en(precise_en),
        .cur_valid(cur_valid), .cur_idx(cur_idx), .cur_val(cur_val),
        .rf_rdata(rf_rdata), .keep_en(keep_en), .keep_acc(keep_acc),
        .we(rf_we), .widx(rf_widx), .wdata(rf_wdata)
    );

    assign rf_ridx = cur_idx;

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rf_we); // R10

    AST_ZERO_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zero_phase && rf_we |-> rf_wdata == '0); // R7

    AST_LOG_EMPTY_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(apply_phase) && !apply_phase |-> slot_valid == '0); // R4

    AST_PUSH_IGNORED_ZERO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        zero_phase && log_push |=> $stable(slot_valid)); // R10

    AST_DIRECT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        !precise_en && apply_phase && rf_we |-> rf_wdata == cur_val); // R5

endmodule

// File: tb/dwb_log_test.sv
`timescale 1ns/1ps
module dwb_log_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        precise_en = 1'b0;
    logic        log_push = 1'b0;
    logic [1:0]  log_slot = '0;
    logic [4:0]  log_idx = '0;
    logic [15:0] log_val = '0;
    logic        apply_req = 1'b0;
    logic        zero_req = 1'b0;
    logic        zero_keep_en = 1'b0;
    logic        zero_keep_acc = 1'b0;
    logic        busy;
    logic [4:0]  rf_ridx;
    logic [15:0] rf_rdata;
    logic        rf_we;
    logic [4:0]  rf_widx;
    logic [15:0] rf_wdata;

    always #2.5 clk = ~clk;

    dwb_log uut (
        .clk(clk), .rst_n(rst_n), .precise_en(precise_en),
        .log_push(log_push), .log_slot(log_slot), .log_idx(log_idx), .log_val(log_val),
        .apply_req(apply_req), .zero_req(zero_req),
        .zero_keep_en(zero_keep_en), .zero_keep_acc(zero_keep_acc),
        .busy(busy), .rf_ridx(rf_ridx), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata)
    );

    // Register file model driven by the block
    logic [15:0] rf [32];
    assign rf_rdata = rf[rf_ridx];
    always @(posedge clk) if (rf_we) rf[rf_widx] <= rf_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Bench view of the log
    bit          m_valid [4];
    logic [4:0]  m_idx   [4];
    logic [15:0] m_val   [4];

    // Recorded writes of one walk
    logic [4:0]  w_idx [8];
    logic [15:0] w_dat [8];
    int          w_cnt;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int filled();
        int n = 0;
        for (int s = 0; s < 4; s++) begin
            if (!m_valid[s]) break;
            n++;
        end
        return n;
    endfunction

    function automatic int busy_len(input int n);
        return (n == 4) ? 4 : n + 1;
    endfunction

    task automatic push(input int s, input logic [4:0] i, input logic [15:0] v);
        log_push = 1'b1; log_slot = 2'(s); log_idx = i; log_val = v;
        @(negedge clk);
        log_push = 1'b0;
        m_valid[s] = 1'b1; m_idx[s] = i; m_val[s] = v;
    endtask

    // Start a walk from idle, optionally disturbing it in its first busy cycle
    task automatic walk(input bit ap, input bit zr, input bit ken, input bit kacc,
                        input bit disturb, output int cyc);
        w_cnt = 0; cyc = 0;
        apply_req = ap; zero_req = zr; zero_keep_en = ken; zero_keep_acc = kacc;
        @(negedge clk);
        apply_req = 1'b0; zero_req = 1'b0;
        while (busy && cyc < 20) begin
            cyc++;
            if (rf_we && w_cnt < 8) begin
                w_idx[w_cnt] = rf_widx; w_dat[w_cnt] = rf_wdata; w_cnt++;
            end
            if (disturb && cyc == 1) begin
                log_push = 1'b1; log_slot = 2'd3; log_idx = 5'd9; log_val = 16'hBEEF;
                apply_req = 1'b1; zero_req = 1'b1;
            end else begin
                log_push = 1'b0; apply_req = 1'b0; zero_req = 1'b0;
            end
            @(negedge clk);
        end
        log_push = 1'b0; apply_req = 1'b0; zero_req = 1'b0;
    endtask

    task automatic check_apply(input string tag, input bit disturb);
        logic [15:0] sh [32];
        logic [4:0]  ei [4];
        logic [15:0] ed [4];
        int n, cyc;
        for (int r = 0; r < 32; r++) sh[r] = rf[r];
        n = filled();
        for (int s = 0; s < n; s++) begin
            ei[s] = m_idx[s];
            ed[s] = precise_en ? (m_val[s] | sh[m_idx[s]]) : m_val[s];
            sh[m_idx[s]] = ed[s];
        end
        walk(1'b1, 1'b0, 1'b0, 1'b0, disturb, cyc);
        chk(w_cnt == n, {tag, " R3 write count"}, w_cnt, n);
        chk(cyc == busy_len(n), {tag, " R3 busy length"}, cyc, busy_len(n));
        for (int s = 0; s < n && s < w_cnt; s++) begin
            chk(w_idx[s] == ei[s], {tag, " R3 order index"}, w_idx[s], ei[s]);
            chk(w_dat[s] == ed[s], precise_en ? {tag, " R6 merged value"} : {tag, " R5 direct value"},
                w_dat[s], ed[s]);
        end
        for (int s = 0; s < 4; s++) m_valid[s] = 1'b0;
        // R4: log must be empty now
        walk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, cyc);
        chk(w_cnt == 0, {tag, " R4 log empty after apply"}, w_cnt, 0);
    endtask

    function automatic bit spared(input logic [4:0] i, input bit ken, input bit kacc);
        return ken && (i == 5'(16 + kacc) || i == 5'(18 + kacc) || i == 5'(20 + kacc));
    endfunction

    task automatic check_zero(input string tag, input bit ken, input bit kacc);
        logic [4:0] ei [4];
        int n, e, cyc;
        n = filled(); e = 0;
        for (int s = 0; s < n; s++)
            if (!spared(m_idx[s], ken, kacc)) begin ei[e] = m_idx[s]; e++; end
        walk(1'b0, 1'b1, ken, kacc, 1'b0, cyc);
        chk(w_cnt == e, {tag, " R7/R8 zero write count"}, w_cnt, e);
        chk(cyc == busy_len(n), {tag, " R7 busy length"}, cyc, busy_len(n));
        for (int s = 0; s < e && s < w_cnt; s++) begin
            chk(w_idx[s] == ei[s], {tag, " R8 zero index"}, w_idx[s], ei[s]);
            chk(w_dat[s] == 16'h0, {tag, " R7 zero data"}, w_dat[s], 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc;
        void'($urandom(32'h5EED));
        for (int r = 0; r < 32; r++) rf[r] = 16'(r * 16'h0111);
        for (int s = 0; s < 4; s++) m_valid[s] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(rf_we == 1'b0, "R1 no write after reset", rf_we, 0);
        walk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, cyc);
        chk(w_cnt == 0, "R1 empty log after reset", w_cnt, 0);

        // R2 overwrite of a slot, R5 direct
        push(0, 5'd3, 16'h1111);
        push(0, 5'd4, 16'h2222);
        push(1, 5'd7, 16'h00F0);
        check_apply("R2 replace", 1'b0);

        // Full log, direct
        push(0, 5'd1, 16'hA000); push(1, 5'd2, 16'h0B00);
        push(2, 5'd3, 16'h00C0); push(3, 5'd4, 16'h000D);
        check_apply("full direct", 1'b0);

        // Gap: slot 2 empty, slot 3 filled -> stops at slot 2 and all cleared
        push(0, 5'd5, 16'h1234); push(1, 5'd6, 16'h5678); push(3, 5'd8, 16'h9ABC);
        m_valid[3] = 1'b0;
        check_apply("gap", 1'b0);

        // R9 zero request in direct mode ignored
        push(0, 5'd10, 16'h0F0F);
        walk(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, cyc);
        chk(cyc == 0, "R9 busy stays low", cyc, 0);
        chk(w_cnt == 0, "R9 no write", w_cnt, 0);
        check_apply("R9 log kept", 1'b0);

        // R10 disturbance during apply
        push(0, 5'd11, 16'h0101); push(1, 5'd12, 16'h0202);
        check_apply("R10 busy ignores push/req", 1'b0 | 1'b1);

        // R11 push together with apply request
        log_push = 1'b1; log_slot = 2'd0; log_idx = 5'd13; log_val = 16'hC0DE;
        walk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, cyc);
        chk(w_cnt == 1 && w_idx[0] == 5'd13, "R11 same-cycle push applied", w_cnt, 1);
        chk(w_dat[0] == 16'hC0DE, "R11 value", w_dat[0], 16'hC0DE);

        // Precise mode: zero with accumulator 1 spared, then merge (R6, R7, R8)
        precise_en = 1'b1;
        push(0, 5'd17, 16'h0011); push(1, 5'd16, 16'h0022);
        push(2, 5'd21, 16'h0044); push(3, 5'd5, 16'h0088);
        check_zero("R8 keep acc1", 1'b1, 1'b1);
        chk(rf[17] == 16'(17 * 16'h0111), "R8 spared register untouched", rf[17], 17 * 16'h0111);
        chk(rf[16] == 16'h0, "R7 zeroed register", rf[16], 0);
        check_apply("R6 after zero", 1'b0);

        // R6 repeated index accumulates
        push(0, 5'd2, 16'h0100); push(1, 5'd2, 16'h0001);
        check_apply("R6 repeat index", 1'b0);

        // R12 apply and zero together: apply wins
        push(0, 5'd9, 16'h4000);
        begin
            logic [15:0] exp_v;
            exp_v = 16'h4000 | rf[9];
            walk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, cyc);
            chk(w_cnt == 1, "R12 single apply write", w_cnt, 1);
            chk(w_dat[0] == exp_v, "R12 apply value not zero", w_dat[0], exp_v);
            m_valid[0] = 1'b0;
        end

        // Constrained random
        for (int it = 0; it < 40; it++) begin
            int n;
            precise_en = 1'($urandom % 2);
            n = $urandom % 5;
            for (int s = 0; s < n; s++)
                push(s, 5'($urandom % 24), 16'($urandom));
            if (precise_en && ($urandom % 2))
                check_zero("random zero R7", 1'($urandom % 2), 1'($urandom % 2));
            check_apply("random apply R3", 1'($urandom % 2));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule